// File: doc/BRIEF.md
# Supply Voltage Change-Detect Monitor

This block watches an external DC supply through an 8-bit converter that it drives over a simple start/done handshake. Software can start a single conversion by writing a go bit. It can also turn on periodic background conversions by writing a nonzero interval. A single conversion always reports its result. A background conversion reports only when the new reading differs from the last reported reading by more than a programmable delta.

Each report sets a sticky flag and loads the new reading into two registers: the visible result register and the internal reference that later background readings are compared against. Because the reference moves only when a report is made, a slow drift still produces a report once its total exceeds the delta. An enable bit gates the flag onto a shared power-management interrupt line. Software reaches the block through a plain register port with a combinational read.

Intended use: run one single conversion to seed the reference, program the delta, then program the background interval.

Top module: `supply_delta_monitor`

## Requirements
- R1: After reset every register reads 0, `pmIrq` is low, and no conversion is started.
- R2: Writing the start register (address 0) with bit 2 set launches exactly one conversion, shown as a one-cycle pulse on `adcStart`. A write to that register with bit 2 clear launches nothing.
- R3: When a single conversion completes, the flag is set and the reading is loaded into the result register (address 5) and the reference register (address 6), whatever the delta setting.
- R4: The flag is bit 3 of the status register (address 2). Writing 1 to that bit clears the flag. Writing 0 to it has no effect.
- R5: `pmIrq` is high exactly when the flag is set and the enable bit (bit 3 of address 1) is 1.
- R6: Background conversions are off while the period register (address 3) is 0. With a nonzero period P, background conversions start every P × TICK_DIV clock cycles.
- R7: A background reading raises an event only if its absolute difference from the reference is strictly greater than (code + 1) × 2 LSB, where code is bits [2:0] of the delta register (address 4). Otherwise the flag, result and reference are left unchanged.
- R8: On every event the result and the reference are both loaded with the new reading, so later comparisons are made against the last reported value and small steps accumulate.
- R9: The absolute difference is correct in both directions over the full range 0 to 255, with no wrap-around.
- R10: If an event and a flag-clear write fall on the same cycle, the flag ends up set.
- R11: A completion pulse on `adcDone` while no conversion is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational from `regAddr`) |
| adcStart | output | 1 | One-cycle conversion request to the converter |
| adcDone | input | 1 | Converter completion pulse |
| adcData | input | 8 | Converter result, valid with `adcDone` |
| pmIrq | output | 1 | Gated power-management interrupt |

## Verification
The bench targets readings that sit exactly on the threshold and one LSB past it. A design that used greater-or-equal would report too early, and one with an off-by-one threshold would miss the step. It moves the supply in small steps that only add up past the delta; a design that compared against the previous reading instead of the last reported one would never fire. It jumps across the whole range in both directions, where an 8-bit subtraction would wrap to a small value and hide the change. It also lands a clear write on the very cycle of an event, where a design that gave the clear priority would lose the report, and it checks the exact spacing between background starts and that a stray completion pulse changes nothing.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  // register addresses
  localparam logic [2:0] ADDR_START  = 3'd0;
  localparam logic [2:0] ADDR_ENABLE = 3'd1;
  localparam logic [2:0] ADDR_STATUS = 3'd2;
  localparam logic [2:0] ADDR_PERIOD = 3'd3;
  localparam logic [2:0] ADDR_DELTA  = 3'd4;
  localparam logic [2:0] ADDR_RESULT = 3'd5;
  localparam logic [2:0] ADDR_REFVAL = 3'd6;

  // bit positions decoded by software
  localparam int GO_BIT  = 2;
  localparam int IRQ_BIT = 3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } convState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic convLaunch;
    logic singleDone;
    logic bgDone;
  } sdmStrobes_t;

endpackage

// File: rtl/sdm_ctrl.sv
module sdm_ctrl
  import sdm_pkg::*;
#(
  parameter int PER_W    = 8,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             goWrite,
  input  logic             periodWrite,
  input  logic [PER_W-1:0] periodData,
  input  logic             adcDone,
  output logic             adcStart,
  output logic [PER_W-1:0] periodValue,
  output sdmStrobes_t      strobes
);

  localparam int TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_DIV - 1);

  convState_t       state;
  logic             kindSingle;
  logic             singlePend;
  logic             bgPend;
  logic [PER_W-1:0] periodReg;
  logic [TICK_W-1:0] tickCnt;
  logic [PER_W-1:0] perCnt;
  logic             tickWrap;
  logic             bgDue;
  logic             launchNow;

  assign tickWrap  = (tickCnt == TICK_LAST);
  assign bgDue     = (periodReg != '0) && tickWrap && (perCnt == periodReg - 1'b1);
  assign launchNow = (state == ST_IDLE) && (singlePend || bgPend);

  // interval timer: prescaler then period counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodReg <= '0;
      tickCnt   <= '0;
      perCnt    <= '0;
    end else if (periodWrite) begin
      periodReg <= periodData;
      tickCnt   <= '0;
      perCnt    <= '0;
    end else if (periodReg == '0) begin
      tickCnt <= '0;
      perCnt  <= '0;
    end else begin
      tickCnt <= tickWrap ? '0 : tickCnt + 1'b1;
      if (tickWrap) begin
        perCnt <= (perCnt == periodReg - 1'b1) ? '0 : perCnt + 1'b1;
      end
    end
  end

  // request capture and conversion sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      kindSingle <= 1'b0;
      singlePend <= 1'b0;
      bgPend     <= 1'b0;
      adcStart   <= 1'b0;
    end else begin
      adcStart <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (launchNow) begin
            state      <= ST_BUSY;
            adcStart   <= 1'b1;
            kindSingle <= singlePend;
            if (singlePend) singlePend <= 1'b0;
            else            bgPend     <= 1'b0;
          end
        end
        ST_BUSY: begin
          if (adcDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (goWrite) singlePend <= 1'b1;
      if (periodWrite) bgPend <= 1'b0;
      else if (bgDue) bgPend <= 1'b1;
    end
  end

  assign periodValue        = periodReg;
  assign strobes.convLaunch = adcStart;
  assign strobes.singleDone = (state == ST_BUSY) && adcDone && kindSingle;
  assign strobes.bgDone     = (state == ST_BUSY) && adcDone && !kindSingle;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);  // R2

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({adcStart, strobes.singleDone, strobes.bgDone}));  // R11

  AST_NO_BG_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (periodReg == '0 && !bgPend && !periodWrite) |=> !(adcStart && !kindSingle));  // R6

endmodule

// File: rtl/sdm_datapath.sv
module sdm_datapath
  import sdm_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DELTA_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  sdmStrobes_t        strobes,
  input  logic [DATA_W-1:0]  adcData,
  input  logic               enWrite,
  input  logic               enData,
  input  logic               deltaWrite,
  input  logic [DELTA_W-1:0] deltaData,
  input  logic               clearWrite,
  output logic [DATA_W-1:0]  resultReg,
  output logic [DATA_W-1:0]  refReg,
  output logic [DELTA_W-1:0] deltaReg,
  output logic               irqEn,
  output logic               flagReg,
  output logic               pmIrq
);

  localparam int DIFF_W = DATA_W + 1;

  logic [DIFF_W-1:0] sampleWide;
  logic [DIFF_W-1:0] refWide;
  logic [DIFF_W-1:0] absDiff;
  logic [DIFF_W-1:0] threshold;
  logic              exceeds;
  logic              eventHit;

  // widened operands so the subtraction never wraps
  assign sampleWide = {1'b0, adcData};
  assign refWide    = {1'b0, refReg};
  assign absDiff    = (sampleWide >= refWide) ? (sampleWide - refWide)
                                              : (refWide - sampleWide);
  assign threshold  = (DIFF_W'(deltaReg) + 1'b1) << 1;
  assign exceeds    = absDiff > threshold;
  assign eventHit   = strobes.singleDone || (strobes.bgDone && exceeds);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      deltaReg <= '0;
      irqEn    <= 1'b0;
    end else begin
      if (deltaWrite) deltaReg <= deltaData;
      if (enWrite)    irqEn    <= enData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultReg <= '0;
      refReg    <= '0;
    end else if (eventHit) begin
      resultReg <= adcData;
      refReg    <= adcData;
    end
  end

  // event outranks a clear on the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)           flagReg <= 1'b0;
    else if (eventHit)   flagReg <= 1'b1;
    else if (clearWrite) flagReg <= 1'b0;
  end

  assign pmIrq = flagReg && irqEn;

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    eventHit |=> flagReg);  // R10

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (clearWrite && !eventHit) |=> !flagReg);  // R4

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !eventHit |=> $stable(resultReg));  // R7

  AST_REF_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    refReg == resultReg);  // R8

endmodule

// File: rtl/supply_delta_monitor.sv
module supply_delta_monitor
  import sdm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DELTA_W  = 3,
  parameter int PER_W    = 8,
  parameter int TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       adcStart,
  input  logic       adcDone,
  input  logic [7:0] adcData,
  output logic       pmIrq
);

  sdmStrobes_t        strobes;
  logic [PER_W-1:0]   periodValue;
  logic [DATA_W-1:0]  resultReg;
  logic [DATA_W-1:0]  refReg;
  logic [DELTA_W-1:0] deltaReg;
  logic               irqEn;
  logic               flagReg;

  logic goWrite, periodWrite, enWrite, deltaWrite, clearWrite;

  assign goWrite     = regWrEn && (regAddr == ADDR_START)  && regWrData[GO_BIT];
  assign periodWrite = regWrEn && (regAddr == ADDR_PERIOD);
  assign enWrite     = regWrEn && (regAddr == ADDR_ENABLE);
  assign deltaWrite  = regWrEn && (regAddr == ADDR_DELTA);
  assign clearWrite  = regWrEn && (regAddr == ADDR_STATUS) && regWrData[IRQ_BIT];

  sdm_ctrl #(
    .PER_W    (PER_W),
    .TICK_DIV (TICK_DIV)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .goWrite     (goWrite),
    .periodWrite (periodWrite),
    .periodData  (regWrData[PER_W-1:0]),
    .adcDone     (adcDone),
    .adcStart    (adcStart),
    .periodValue (periodValue),
    .strobes     (strobes)
  );

  sdm_datapath #(
    .DATA_W  (DATA_W),
    .DELTA_W (DELTA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .adcData    (adcData[DATA_W-1:0]),
    .enWrite    (enWrite),
    .enData     (regWrData[IRQ_BIT]),
    .deltaWrite (deltaWrite),
    .deltaData  (regWrData[DELTA_W-1:0]),
    .clearWrite (clearWrite),
    .resultReg  (resultReg),
    .refReg     (refReg),
    .deltaReg   (deltaReg),
    .irqEn      (irqEn),
    .flagReg    (flagReg),
    .pmIrq      (pmIrq)
  );

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_ENABLE: regRdData[IRQ_BIT] = irqEn;
      ADDR_STATUS: regRdData[IRQ_BIT] = flagReg;
      ADDR_PERIOD: regRdData = 8'(periodValue);
      ADDR_DELTA:  regRdData = 8'(deltaReg);
      ADDR_RESULT: regRdData = 8'(resultReg);
      ADDR_REFVAL: regRdData = 8'(refReg);
      default:     regRdData = '0;
    endcase
  end

endmodule

// File: tb/supply_delta_monitor_tb.sv
module supply_delta_monitor_tb;

  localparam int TICK_DIV = 4;
  localparam int ADC_LAT  = 3;

  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn;
  logic [2:0] regAddr;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       adcStart;
  logic       adcDone;
  logic [7:0] adcData;
  logic       pmIrq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int convCount = 0;
  int startPrev = 0;
  int startLast = 0;
  logic [7:0] adcValue = 8'd0;
  logic syncClear = 1'b0;
  logic finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  supply_delta_monitor #(.TICK_DIV(TICK_DIV)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .adcStart(adcStart),
    .adcDone(adcDone), .adcData(adcData), .pmIrq(pmIrq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output int v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic waitConv();
    int c0 = convCount;
    while (convCount == c0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expectRegs(input string req, input int flag, input int res);
    int v;
    regRead(3'd2, v); check({req, " flag"}, (v >> 3) & 1, flag);
    regRead(3'd5, v); check({req, " result"}, v, res);
    regRead(3'd6, v); check({req, " reference"}, v, res);
  endtask

  // converter model
  initial begin
    adcDone = 1'b0;
    adcData = 8'd0;
    forever begin
      @(negedge clk);
      if (adcStart) begin
        startPrev = startLast;
        startLast = cyc;
        repeat (ADC_LAT) @(negedge clk);
        adcData = adcValue;
        adcDone = 1'b1;
        if (syncClear) begin
          regWrEn = 1'b1; regAddr = 3'd2; regWrData = 8'h08;
        end
        @(negedge clk);
        adcDone = 1'b0;
        if (syncClear) regWrEn = 1'b0;
        convCount++;
      end
    end
  end

  task automatic testReset();
    int v;
    for (int a = 0; a < 7; a++) begin
      regRead(3'(a), v);
      check("R1 register after reset", v, 0);
    end
    check("R1 irq after reset", pmIrq, 0);
    repeat (100) @(negedge clk);
    check("R1 no conversion after reset", convCount, 0);
  endtask

  task automatic testGoBit();
    adcValue = 8'd100;
    regWrite(3'd0, 8'h03);
    repeat (20) @(negedge clk);
    check("R2 bit2 clear launches nothing", convCount, 0);
    regWrite(3'd0, 8'h04);
    waitConv();
    check("R2 one conversion", convCount, 1);
    repeat (20) @(negedge clk);
    check("R2 no extra conversion", convCount, 1);
    expectRegs("R3 single", 1, 100);
  endtask

  task automatic testIrqAndClear();
    int v;
    check("R5 irq gated off", pmIrq, 0);
    regWrite(3'd1, 8'h08);
    regRead(3'd1, v);
    check("R5 enable readback", v, 8);
    check("R5 irq on", pmIrq, 1);
    regWrite(3'd2, 8'h00);
    regWrite(3'd2, 8'hF7);
    regRead(3'd2, v);
    check("R4 write 0 keeps flag", v, 8);
    regWrite(3'd2, 8'h08);
    regRead(3'd2, v);
    check("R4 write 1 clears", v, 0);
    check("R5 irq off after clear", pmIrq, 0);
  endtask

  task automatic testDelta();
    regWrite(3'd4, 8'd2);   // threshold 6
    regWrite(3'd3, 8'd5);   // 20 cycles
    adcValue = 8'd106;
    waitConv();
    expectRegs("R7 diff equal threshold", 0, 100);
    adcValue = 8'd107;
    waitConv();
    expectRegs("R7 diff over threshold", 1, 107);
    regWrite(3'd2, 8'h08);
  endtask

  task automatic testInterval();
    waitConv();
    waitConv();
    check("R6 background interval", startLast - startPrev, 5 * TICK_DIV);
  endtask

  task automatic testDrift();
    adcValue = 8'd109; waitConv(); expectRegs("R8 drift 2", 0, 107);
    adcValue = 8'd111; waitConv(); expectRegs("R8 drift 4", 0, 107);
    adcValue = 8'd113; waitConv(); expectRegs("R8 drift 6", 0, 107);
    adcValue = 8'd114; waitConv(); expectRegs("R8 drift 7", 1, 114);
    regWrite(3'd2, 8'h08);
  endtask

  task automatic testWrap();
    regWrite(3'd4, 8'd7);   // threshold 16
    adcValue = 8'd3;   waitConv(); expectRegs("R9 large fall", 1, 3);
    regWrite(3'd2, 8'h08);
    adcValue = 8'd255; waitConv(); expectRegs("R9 full rise", 1, 255);
    regWrite(3'd2, 8'h08);
    regWrite(3'd4, 8'd0);   // threshold 2
    adcValue = 8'd253; waitConv(); expectRegs("R9 fall equal", 0, 255);
    adcValue = 8'd252; waitConv(); expectRegs("R9 fall over", 1, 252);
    regWrite(3'd2, 8'h08);
  endtask

  task automatic testSyncClear();
    syncClear = 1'b1;
    adcValue = 8'd200;
    waitConv();
    syncClear = 1'b0;
    expectRegs("R10 event beats clear", 1, 200);
    check("R10 irq", pmIrq, 1);
    regWrite(3'd2, 8'h08);
  endtask

  task automatic testStopAndIdle();
    int c0;
    regWrite(3'd3, 8'd0);
    repeat (30) @(negedge clk);
    c0 = convCount;
    repeat (120) @(negedge clk);
    check("R6 period zero stops", convCount, c0);
    @(negedge clk);
    adcData = 8'd77; adcDone = 1'b1;
    @(negedge clk);
    adcDone = 1'b0;
    repeat (3) @(negedge clk);
    expectRegs("R11 stray done", 0, 200);
  endtask

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 3'd0; regWrData = 8'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testGoBit();
    testIrqAndClear();
    testDelta();
    testInterval();
    testDrift();
    testWrap();
    testSyncClear();
    testStopAndIdle();
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule